// File: doc/BRIEF.md
# Integer Execute Unit for Arithmetic, Logic and Shifts

This block carries out the register-to-register and register-immediate computations of a 32-bit load-store processor in a single clocked step. Each cycle in which `in_valid` is high, it takes an operation code, two operand words (the first and second source register values), a 17-bit immediate constant and a 5-bit shift-amount field. One clock edge later it presents a 32-bit result and a write strobe for the destination register.

The unit has a two's complement adder/subtractor, a bitwise logic stage, sign extension for the immediate constant, and a barrel shifter. The barrel shifter supports logical right, arithmetic right, logical left and rotate-left shifts. The shift amount comes from the instruction field when that field is nonzero. When the field is zero, the amount comes from the five low bits of the second source operand. Register-file reads and writes, memory traffic and control flow belong to neighbouring blocks.

Top module: `exu_top`

## Requirements
- R1: Operation codes (decimal): add 12 gives `src_b + src_c`; sub 14 gives `src_b - src_c`; neg 15 gives `-src_c`. All are modulo 2^32 and ignore carry out.
- R2: Operation codes and 20, or 22 and not 24 give `src_b & src_c`, `src_b | src_c` and `~src_c`. For neg and not, `src_b` has no effect on the result.
- R3: Operation codes addi 13, andi 21 and ori 23 use `imm17` sign-extended from its bit 16 to 32 bits in place of `src_c`.
- R4: Operation code 26 shifts `src_b` right and fills with zeros. Operation code 27 shifts right and fills with copies of `src_b[31]`. For example, 0x97EAEC16 shifted arithmetically by 13 gives 0xFFFCBF57.
- R5: Operation code 28 shifts `src_b` left and fills with zeros. Operation code 29 rotates `src_b` left, so bits leaving at bit 31 re-enter at bit 0.
- R6: The shift amount is `shamt` when `shamt` is nonzero, and `src_c[4:0]` otherwise. With `shamt` nonzero, `src_c` has no effect on a shift result.
- R7: An effective shift amount of 0 returns `src_b` unchanged for all four shift kinds.
- R8: Valid inputs with any operation code other than 12–15, 20–24 and 26–29 produce `wr_en` low on the next cycle.
- R9: `result` and `wr_en` are registered and appear one cycle after inputs sampled with `in_valid` high. `wr_en` is low in the cycle after `in_valid` is low, and it is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Inputs hold an operation this cycle |
| opcode | input | 5 | Operation code |
| src_b | input | 32 | First source operand |
| src_c | input | 32 | Second source operand |
| imm17 | input | 17 | Immediate constant, two's complement |
| shamt | input | 5 | Shift-amount field from the instruction |
| result | output | 32 | Registered result |
| wr_en | output | 1 | Destination register write strobe |

## Verification
The arithmetic operations are driven with operand pairs that wrap around 2^32 and with signed negative values, which separates correct modulo behaviour from carry or sign mistakes. Immediate operations use constants with bit 16 set and with it clear, so sign extension can be told apart from zero extension. Shifts use an operand whose bit 31 is set, across amounts 0, 1, 13 and 31. This distinguishes zero fill from sign fill and rotation from plain shifting. The same amounts are also supplied through the register path, alongside a nonzero field paired with a conflicting register value, which checks which source selects the amount. Unused operation codes and idle cycles confirm that the write strobe stays low.

// File: rtl/exu_pkg.sv
package exu_pkg;
    localparam int XLEN   = 32;
    localparam int OPW    = 5;
    localparam int IMMW   = 17;
    localparam int SHW    = $clog2(XLEN);

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd12,
        OP_ADDI = 5'd13,
        OP_SUB  = 5'd14,
        OP_NEG  = 5'd15,
        OP_AND  = 5'd20,
        OP_ANDI = 5'd21,
        OP_OR   = 5'd22,
        OP_ORI  = 5'd23,
        OP_NOT  = 5'd24,
        OP_SHR  = 5'd26,
        OP_SHRA = 5'd27,
        OP_SHL  = 5'd28,
        OP_SHC  = 5'd29
    } op_e;

    typedef enum logic [1:0] {
        SK_LSR = 2'd0,
        SK_ASR = 2'd1,
        SK_LSL = 2'd2,
        SK_ROL = 2'd3
    } shkind_e;

    typedef enum logic [1:0] {
        UNIT_ARITH = 2'd0,
        UNIT_LOGIC = 2'd1,
        UNIT_SHIFT = 2'd2,
        UNIT_NONE  = 2'd3
    } unit_e;

    typedef struct packed {
        unit_e         unit;
        logic          use_imm;
        logic          zero_a;
        logic          do_sub;
        logic [1:0]    lop;
        shkind_e       sk;
        logic          writes;
    } ctl_t;
endpackage

// File: rtl/exu_decode.sv
// exu_decode: turns an operation code into control fields for the datapath.
// Assumes: codes outside the known set map to a non-writing control word.
module exu_decode
    import exu_pkg::*;
(
    input  logic [OPW-1:0] opcode,
    output ctl_t           ctl
);
    // Purpose: combinational lookup from code to control word.
    always_comb begin
        ctl         = '0;
        ctl.unit    = UNIT_NONE;
        ctl.sk      = SK_LSR;
        case (opcode)
            OP_ADD:  begin ctl.unit = UNIT_ARITH; ctl.writes = 1'b1; end
            OP_ADDI: begin ctl.unit = UNIT_ARITH; ctl.use_imm = 1'b1; ctl.writes = 1'b1; end
            OP_SUB:  begin ctl.unit = UNIT_ARITH; ctl.do_sub = 1'b1; ctl.writes = 1'b1; end
            OP_NEG:  begin ctl.unit = UNIT_ARITH; ctl.do_sub = 1'b1; ctl.zero_a = 1'b1; ctl.writes = 1'b1; end
            OP_AND:  begin ctl.unit = UNIT_LOGIC; ctl.lop = 2'd0; ctl.writes = 1'b1; end
            OP_ANDI: begin ctl.unit = UNIT_LOGIC; ctl.lop = 2'd0; ctl.use_imm = 1'b1; ctl.writes = 1'b1; end
            OP_OR:   begin ctl.unit = UNIT_LOGIC; ctl.lop = 2'd1; ctl.writes = 1'b1; end
            OP_ORI:  begin ctl.unit = UNIT_LOGIC; ctl.lop = 2'd1; ctl.use_imm = 1'b1; ctl.writes = 1'b1; end
            OP_NOT:  begin ctl.unit = UNIT_LOGIC; ctl.lop = 2'd2; ctl.writes = 1'b1; end
            OP_SHR:  begin ctl.unit = UNIT_SHIFT; ctl.sk = SK_LSR; ctl.writes = 1'b1; end
            OP_SHRA: begin ctl.unit = UNIT_SHIFT; ctl.sk = SK_ASR; ctl.writes = 1'b1; end
            OP_SHL:  begin ctl.unit = UNIT_SHIFT; ctl.sk = SK_LSL; ctl.writes = 1'b1; end
            OP_SHC:  begin ctl.unit = UNIT_SHIFT; ctl.sk = SK_ROL; ctl.writes = 1'b1; end
            default: begin ctl.unit = UNIT_NONE; end
        endcase
    end
endmodule

// File: rtl/exu_shifter.sv
// exu_shifter: logarithmic barrel shifter with four kinds.
// Assumes: a right-rotating core; left kinds are handled by bit reversal.
module exu_shifter
    import exu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int SW = $clog2(W)
)(
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  shkind_e       kind,
    output logic [W-1:0]  dout
);
    localparam int STAGES = SW;

    logic          left;
    logic          fill;
    logic          rot;
    logic [W-1:0]  pre;
    logic [W-1:0]  stg [STAGES+1];

    // Purpose: pick direction, fill bit and rotate flag from the kind.
    always_comb begin
        left = (kind == SK_LSL) || (kind == SK_ROL);
        rot  = (kind == SK_ROL);
        fill = (kind == SK_ASR) ? din[W-1] : 1'b0;
    end

    // Purpose: reverse bits for left kinds so the core only moves right.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            pre[i] = left ? din[W-1-i] : din[i];
        end
    end

    assign stg[0] = pre;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            localparam int D = 1 << s;
            logic [D-1:0] inject;
            // Purpose: bits entering at the top for this stage (reversed rotate-left is rotate-right).
            always_comb begin
                inject = rot ? stg[s][D-1:0] : {D{fill}};
            end
            assign stg[s+1] = amt[s] ? {inject, stg[s][W-1:D]} : stg[s];
        end
    endgenerate

    // Purpose: undo the reversal for left kinds.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            dout[i] = left ? stg[STAGES][W-1-i] : stg[STAGES][i];
        end
    end
endmodule

// File: rtl/exu_alu.sv
// exu_alu: adder/subtractor and bitwise logic on whole words.
// Assumes: operand b is already the immediate or src_c as chosen upstream.
module exu_alu
    import exu_pkg::*;
#(
    parameter int W = XLEN
)(
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  ctl_t         ctl,
    output logic [W-1:0] arith,
    output logic [W-1:0] logic_r
);
    logic [W-1:0] a_eff;
    logic [W-1:0] b_eff;

    // Purpose: two's complement add, with inversion and carry-in for subtract.
    always_comb begin
        a_eff = ctl.zero_a ? '0 : opa;
        b_eff = ctl.do_sub ? ~opb : opb;
        arith = a_eff + b_eff + {{(W-1){1'b0}}, ctl.do_sub};
    end

    // Purpose: bitwise and / or / not.
    always_comb begin
        case (ctl.lop)
            2'd0:    logic_r = opa & opb;
            2'd1:    logic_r = opa | opb;
            default: logic_r = ~opb;
        endcase
    end
endmodule

// File: rtl/exu_top.sv
// exu_top: execute step for arithmetic, logic and shift operations.
// Assumes: operands are presented with in_valid; outputs follow one edge later.
module exu_top
    import exu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [OPW-1:0]       opcode,
    input  logic [XLEN-1:0]      src_b,
    input  logic [XLEN-1:0]      src_c,
    input  logic [IMMW-1:0]      imm17,
    input  logic [SHW-1:0]       shamt,
    output logic [XLEN-1:0]      result,
    output logic                 wr_en
);
    ctl_t            ctl;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] opnd_b;
    logic [SHW-1:0]  n_eff;
    logic [XLEN-1:0] arith_r;
    logic [XLEN-1:0] logic_r;
    logic [XLEN-1:0] shift_r;
    logic [XLEN-1:0] res_d;

    exu_decode u_dec (.opcode(opcode), .ctl(ctl));

    // Purpose: sign-extend the immediate and choose the second operand.
    always_comb begin
        imm_ext = {{(XLEN-IMMW){imm17[IMMW-1]}}, imm17};
        opnd_b  = ctl.use_imm ? imm_ext : src_c;
    end

    // Purpose: shift amount from the field, or from the register when the field is zero.
    always_comb begin
        n_eff = (shamt != '0) ? shamt : src_c[SHW-1:0];
    end

    exu_alu #(.W(XLEN)) u_alu (
        .opa(src_b), .opb(opnd_b), .ctl(ctl),
        .arith(arith_r), .logic_r(logic_r)
    );

    exu_shifter #(.W(XLEN), .SW(SHW)) u_shf (
        .din(src_b), .amt(n_eff), .kind(ctl.sk), .dout(shift_r)
    );

    // Purpose: select the unit output.
    always_comb begin
        case (ctl.unit)
            UNIT_ARITH: res_d = arith_r;
            UNIT_LOGIC: res_d = logic_r;
            UNIT_SHIFT: res_d = shift_r;
            default:    res_d = '0;
        endcase
    end

    // Purpose: register result and write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            wr_en  <= 1'b0;
        end else begin
            wr_en <= in_valid && ctl.writes;
            if (in_valid) begin
                result <= res_d;
            end
        end
    end
endmodule

// File: rtl/exu_checker.sv
// exu_checker: temporal properties on the execute unit ports.
module exu_checker
    import exu_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [OPW-1:0]  opcode,
    input logic [XLEN-1:0] src_b,
    input logic [XLEN-1:0] src_c,
    input logic [IMMW-1:0] imm17,
    input logic [SHW-1:0]  shamt,
    input logic [XLEN-1:0] result,
    input logic            wr_en
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !in_valid |=> !wr_en); // R9
    AST_UNUSED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && in_valid && (opcode == 5'd0 || opcode == 5'd31 || opcode == 5'd25) |=> !wr_en); // R8
    AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && in_valid && opcode == 5'd12 |=> wr_en && result == $past(src_b) + $past(src_c)); // R1
    AST_NOT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && in_valid && opcode == 5'd24 |=> result == ~$past(src_c)); // R2
    AST_ZERO_SHIFT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && in_valid && opcode >= 5'd26 && opcode <= 5'd29 && shamt == '0 && src_c[4:0] == '0
        |=> result == $past(src_b)); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !in_valid |=> $stable(result)); // R9
endmodule

bind exu_top exu_checker u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .src_b(src_b), .src_c(src_c), .imm17(imm17), .shamt(shamt),
    .result(result), .wr_en(wr_en)
);

// File: tb/tb_exu_top.sv
module tb_exu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  opcode = '0;
    logic [31:0] src_b = '0;
    logic [31:0] src_c = '0;
    logic [16:0] imm17 = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        wr_en;

    int n_cmp = 0;
    int n_bad = 0;

    exu_top dut (.*);

    always #5 clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one operation at the falling edge, sample one edge later at the next falling edge.
    task automatic run(input logic [4:0] op, input logic [31:0] b, input logic [31:0] c,
                       input logic [16:0] im, input logic [4:0] n,
                       output logic [31:0] r, output logic we);
        @(negedge clk);
        in_valid = 1'b1; opcode = op; src_b = b; src_c = c; imm17 = im; shamt = n;
        @(negedge clk);
        in_valid = 1'b0;
        r = result; we = wr_en;
    endtask

    function automatic logic [31:0] rol(logic [31:0] v, int k);
        return (k == 0) ? v : ((v << k) | (v >> (32 - k)));
    endfunction

    task automatic t_reset();
        check("R9 reset wr_en", {31'b0, wr_en}, 32'd0);
        check("R9 reset result", result, 32'd0);
    endtask

    task automatic t_arith();
        logic [31:0] r; logic we;
        run(5'd12, 32'hFFFF_FFF0, 32'h0000_0020, '0, '0, r, we);
        check("R1 add wrap", r, 32'h0000_0010); check("R9 add wr_en", {31'b0, we}, 32'd1);
        run(5'd14, 32'h0000_0003, 32'h0000_0005, '0, '0, r, we);
        check("R1 sub neg", r, 32'hFFFF_FFFE);
        run(5'd15, 32'h1234_5678, 32'h0000_0007, '0, '0, r, we);
        check("R1 neg", r, 32'hFFFF_FFF9);
        run(5'd15, 32'h0, 32'h8000_0000, '0, '0, r, we);
        check("R1 neg min", r, 32'h8000_0000);
    endtask

    task automatic t_logic();
        logic [31:0] r; logic we;
        run(5'd20, 32'hF0F0_F0F0, 32'hFF00_FF00, '0, '0, r, we);
        check("R2 and", r, 32'hF000_F000);
        run(5'd22, 32'hF0F0_F0F0, 32'h0F00_000F, '0, '0, r, we);
        check("R2 or", r, 32'hFFF0_F0FF);
        run(5'd24, 32'hDEAD_BEEF, 32'h0000_FFFF, '0, '0, r, we);
        check("R2 not ignores src_b", r, 32'hFFFF_0000);
    endtask

    task automatic t_imm();
        logic [31:0] r; logic we;
        run(5'd13, 32'h0000_0100, 32'h5555_5555, 17'h1FFFF, '0, r, we);
        check("R3 addi negative", r, 32'h0000_00FF);
        run(5'd13, 32'h0000_0100, 32'h0, 17'h0FFFF, '0, r, we);
        check("R3 addi positive", r, 32'h0001_00FF);
        run(5'd21, 32'hFFFF_FFFF, 32'h0, 17'h10001, '0, r, we);
        check("R3 andi sext", r, 32'hFFFF_0001);
        run(5'd23, 32'h0000_0000, 32'h0, 17'h10000, '0, r, we);
        check("R3 ori sext", r, 32'hFFFF_0000);
    endtask

    task automatic t_shift();
        logic [31:0] r; logic we;
        logic [31:0] v = 32'h97EA_EC16;
        run(5'd27, v, 32'h0, '0, 5'd13, r, we);
        check("R4 shra 13", r, 32'hFFFC_BF57);
        run(5'd26, v, 32'h0, '0, 5'd13, r, we);
        check("R4 shr 13", r, v >> 13);
        run(5'd27, v, 32'h0, '0, 5'd31, r, we);
        check("R4 shra 31", r, 32'hFFFF_FFFF);
        run(5'd28, v, 32'h0, '0, 5'd1, r, we);
        check("R5 shl 1", r, v << 1);
        run(5'd29, v, 32'h0, '0, 5'd13, r, we);
        check("R5 shc 13", r, rol(v, 13));
        run(5'd29, v, 32'h0, '0, 5'd31, r, we);
        check("R5 shc 31", r, rol(v, 31));
    endtask

    task automatic t_amount();
        logic [31:0] r; logic we;
        logic [31:0] v = 32'h97EA_EC16;
        run(5'd26, v, 32'hFFFF_FFE4, '0, 5'd0, r, we);
        check("R6 register amount 4", r, v >> 4);
        run(5'd28, v, 32'h0000_001F, '0, 5'd2, r, we);
        check("R6 field wins over register", r, v << 2);
        run(5'd29, v, 32'h0000_0108, '0, 5'd0, r, we);
        check("R6 register rotate 8", r, rol(v, 8));
    endtask

    task automatic t_zero();
        logic [31:0] r; logic we;
        logic [31:0] v = 32'h97EA_EC16;
        for (int k = 26; k <= 29; k++) begin
            run(k[4:0], v, 32'hFFFF_FFE0, '0, 5'd0, r, we);
            check("R7 zero amount pass", r, v);
        end
    endtask

    task automatic t_unused();
        logic [31:0] r; logic we;
        logic [4:0] codes [5] = '{5'd0, 5'd1, 5'd25, 5'd30, 5'd31};
        foreach (codes[i]) begin
            run(codes[i], 32'h1, 32'h2, '0, '0, r, we);
            check("R8 unused code no write", {31'b0, we}, 32'd0);
        end
        @(negedge clk);
        check("R9 idle no write", {31'b0, wr_en}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_arith();
        t_logic();
        t_imm();
        t_shift();
        t_amount();
        t_zero();
        t_unused();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule